// File: doc/BRIEF.md
# Real-Time Clock Control Register and Shared Interrupt/Square-Wave Pin

This block holds the 8-bit control register of a real-time clock and drives the single output pin. That pin carries either a square wave or an alarm interrupt. Software reaches the register over a plain register bus. Reads use address 0x0E. Writes use address 0x8E, which is the read address with bit 7 set. The register sets four things: whether the oscillator may stop while on battery, whether the pin stays active on battery, which of four square-wave rates is produced, and whether the pin carries the square wave or the gated alarm flags.

The square wave comes from a 15-bit divider. The divider advances on each 32.768 kHz tick while the oscillator runs. The pin is active-low open-drain. It is modelled with two outputs: `pin_oe` enables the driver and `pin_drive_low` pulls the pin low. A square-wave high level is released rather than driven. A temperature-conversion request bit sits in the same register. A bus write can only set it, and a conversion-done input clears it.

Top module: `rtc_ctrl_pin`

## Requirements
- R1: After reset the register reads 0x1C (bit 4:3 rate code = 11, bit 2 interrupt mode = 1, all other bits 0) and `conv_req` is 0.
- R2: A write with `bus_addr` = 0x8E loads bits 7, 6 and 4:0 from `bus_wdata` on the next clock edge. Writes to any other address change nothing. `bus_rdata` shows the register when `bus_addr` = 0x0E and 0 for any other address.
- R3: The conversion bit (bit 5, seen on `conv_req`) is set by a 0x8E write with bit 5 = 1. A written 0 is ignored. `conv_done` clears the bit on the next edge unless a setting write arrives in the same cycle, in which case the bit stays 1.
- R4: `osc_run` is 1 whenever `vcc_ok` = 1. With `vcc_ok` = 0, it equals the inverse of bit 7.
- R5: The divider counts `tick_32k` pulses only while `osc_run` = 1, starting from 0 at reset. The square-wave level is divider bit 14 for rate code 00 (1 Hz), bit 4 for 01 (1.024 kHz), bit 2 for 10 (4.096 kHz) and bit 1 for 11 (8.192 kHz).
- R6: With bit 2 = 0 and the pin enabled, `pin_drive_low` is the inverse of the square-wave level.
- R7: With bit 2 = 1 and the pin enabled, `pin_drive_low` = (`alarm1_flag` & bit 0) | (`alarm2_flag` & bit 1).
- R8: `pin_oe` = `vcc_ok` | bit 6. When `pin_oe` = 0, `pin_drive_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz period |
| vcc_ok | input | 1 | Primary supply present (0 means battery) |
| alarm1_flag | input | 1 | Alarm 1 match flag |
| alarm2_flag | input | 1 | Alarm 2 match flag |
| conv_done | input | 1 | Temperature conversion finished |
| osc_run | output | 1 | Oscillator run enable |
| conv_req | output | 1 | Pending conversion request |
| pin_drive_low | output | 1 | Pull the shared pin low |
| pin_oe | output | 1 | Shared pin driver enable |

## Verification
Two events can land in the same clock cycle: a register write that sets the conversion bit, and the `conv_done` pulse that clears it. The write must win, so the bit stays 1. The random stimulus makes this collision often, and a directed case forces it. A bench model that applies the write last predicts the result. A similar overlap happens when a rate or mode write lands on the same edge as a divider step. The bench checks the pin against its own tick count in the cycle after each such edge.

// File: rtl/rtc_ctrl_pkg.sv
package rtc_ctrl_pkg;
    localparam int          REG_W   = 8;
    localparam int          ADDR_W  = 8;
    localparam logic [7:0]  RD_ADDR = 8'h0E;
    localparam logic [7:0]  WR_ADDR = 8'h8E;
    localparam logic [7:0]  RST_VAL = 8'h1C;

    typedef enum logic [1:0] {
        RATE_1HZ = 2'b00,
        RATE_1K  = 2'b01,
        RATE_4K  = 2'b10,
        RATE_8K  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  osc_stop;   // bit 7: oscillator may stop on battery
        logic  bat_pin;    // bit 6: keep pin active on battery
        logic  conv;       // bit 5: conversion request
        rate_e rate;       // bits 4:3
        logic  irq_mode;   // bit 2: 1 = interrupt, 0 = square wave
        logic  al2_en;     // bit 1
        logic  al1_en;     // bit 0
    } ctrl_t;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_ctrl_pkg::*;
#(
    parameter int         AW    = ADDR_W,
    parameter logic [7:0] RADDR = RD_ADDR,
    parameter logic [7:0] WADDR = WR_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic          conv_done_i,
    output ctrl_t         ctrl_o,
    output logic [REG_W-1:0] rdata_o
);
    typedef struct packed {
        ctrl_t ctrl;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit;
    logic    set_conv;
    ctrl_t   wr_view;

    always_comb begin
        wr_view  = ctrl_t'(wdata_i);
        hit      = wr_i && (addr_i == AW'(WADDR));
        set_conv = hit && wr_view.conv;
        st_d     = st_q;
        if (hit) begin
            st_d.ctrl      = wr_view;
            st_d.ctrl.conv = st_q.ctrl.conv;
        end
        if (conv_done_i) st_d.ctrl.conv = 1'b0;
        if (set_conv)    st_d.ctrl.conv = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reg_st_t'(RST_VAL);
        else        st_q <= st_d;
    end

    assign ctrl_o  = st_q.ctrl;
    assign rdata_o = (addr_i == AW'(RADDR)) ? st_q.ctrl : '0;

    a_r3_conv_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o.conv && !conv_done_i) |=> ctrl_o.conv);
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && !(wr_i && addr_i == AW'(WADDR) && wdata_i[5])) |=> !ctrl_o.conv);
    a_r2_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done_i && !(wr_i && addr_i == AW'(WADDR))) |=> $stable(ctrl_o));
endmodule

// File: rtl/rtc_sqw_div.sv
module rtc_sqw_div
    import rtc_ctrl_pkg::*;
#(
    parameter int DIV_W   = 15,
    parameter int TAP_1HZ = DIV_W - 1,
    parameter int TAP_1K  = 4,
    parameter int TAP_4K  = 2,
    parameter int TAP_8K  = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_i,
    input  rate_e rate_i,
    output logic  sq_o
);
    localparam int NRATE = 4;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [NRATE-1:0] taps;

    always_comb begin
        st_d = st_q;
        if (adv_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    localparam int TAPS [NRATE] = '{TAP_1HZ, TAP_1K, TAP_4K, TAP_8K};
    for (genvar g = 0; g < NRATE; g++) begin : g_tap
        assign taps[g] = st_q.cnt[TAPS[g]];
    end

    assign sq_o = taps[rate_i];

    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(st_q.cnt));
    a_r5_step_once: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (st_q.cnt == DIV_W'($past(st_q.cnt) + 1'b1)));
endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
    import rtc_ctrl_pkg::*;
(
    input  ctrl_t ctrl_i,
    input  logic  vcc_ok_i,
    input  logic  sq_i,
    input  logic  al1_i,
    input  logic  al2_i,
    output logic  osc_run_o,
    output logic  drive_low_o,
    output logic  oe_o
);
    logic irq;
    logic low_lvl;

    always_comb begin
        irq         = (al1_i && ctrl_i.al1_en) || (al2_i && ctrl_i.al2_en);
        low_lvl     = ctrl_i.irq_mode ? irq : !sq_i;
        oe_o        = vcc_ok_i || ctrl_i.bat_pin;
        drive_low_o = oe_o && low_lvl;
        osc_run_o   = vcc_ok_i || !ctrl_i.osc_stop;
    end
endmodule

// File: rtl/rtc_ctrl_pin.sv
module rtc_ctrl_pin
    import rtc_ctrl_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tick_32k,
    input  logic       vcc_ok,
    input  logic       alarm1_flag,
    input  logic       alarm2_flag,
    input  logic       conv_done,
    output logic       osc_run,
    output logic       conv_req,
    output logic       pin_drive_low,
    output logic       pin_oe
);
    ctrl_t ctrl;
    logic  sq;

    rtc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .conv_done_i(conv_done),
        .ctrl_o     (ctrl),
        .rdata_o    (bus_rdata)
    );

    rtc_sqw_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (tick_32k && osc_run),
        .rate_i(ctrl.rate),
        .sq_o  (sq)
    );

    rtc_pin_mux u_mux (
        .ctrl_i     (ctrl),
        .vcc_ok_i   (vcc_ok),
        .sq_i       (sq),
        .al1_i      (alarm1_flag),
        .al2_i      (alarm2_flag),
        .osc_run_o  (osc_run),
        .drive_low_o(pin_drive_low),
        .oe_o       (pin_oe)
    );

    assign conv_req = ctrl.conv;

    a_r4_mains_runs: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_ok |-> osc_run);
    a_r8_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_drive_low);
    a_r8_mains_drives: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_ok |-> pin_oe);
    a_r7_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.irq_mode && !alarm1_flag && !alarm2_flag) |-> !pin_drive_low);
endmodule

// File: tb/rtc_ctrl_pin_tb.sv
module rtc_ctrl_pin_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_32k = 1'b0;
    logic       vcc_ok = 1'b1;
    logic       alarm1_flag = 1'b0;
    logic       alarm2_flag = 1'b0;
    logic       conv_done = 1'b0;
    logic       osc_run, conv_req, pin_drive_low, pin_oe;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 0;

    logic [7:0]  m_ctrl;
    logic [14:0] m_cnt;

    always #4 clk = ~clk;

    rtc_ctrl_pin u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_32k(tick_32k),
        .vcc_ok(vcc_ok), .alarm1_flag(alarm1_flag), .alarm2_flag(alarm2_flag),
        .conv_done(conv_done), .osc_run(osc_run), .conv_req(conv_req),
        .pin_drive_low(pin_drive_low), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic exp_sq(input logic [7:0] c, input logic [14:0] n);
        case (c[4:3])
            2'b00:   return n[14];
            2'b01:   return n[4];
            2'b10:   return n[2];
            default: return n[1];
        endcase
    endfunction

    // One cycle: drive at the falling edge, check outputs, advance the model, cross the rising edge.
    task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] w,
                        input logic tk, input logic vc, input logic f1, input logic f2,
                        input logic dn);
        logic e_osc, e_oe, e_irq, e_low;
        bus_wr = wr; bus_addr = a; bus_wdata = w; tick_32k = tk;
        vcc_ok = vc; alarm1_flag = f1; alarm2_flag = f2; conv_done = dn;
        #1;
        e_osc = vc | ~m_ctrl[7];
        e_oe  = vc | m_ctrl[6];
        e_irq = (f1 & m_ctrl[0]) | (f2 & m_ctrl[1]);
        e_low = e_oe & (m_ctrl[2] ? e_irq : ~exp_sq(m_ctrl, m_cnt));
        check("R2", bus_rdata, (a == 8'h0E) ? m_ctrl : 8'h00);
        check("R3", {7'd0, conv_req}, {7'd0, m_ctrl[5]});
        check("R4", {7'd0, osc_run}, {7'd0, e_osc});
        check("R8", {7'd0, pin_oe}, {7'd0, e_oe});
        if (!e_oe)           check("R8", {7'd0, pin_drive_low}, 8'd0);
        else if (m_ctrl[2])  check("R7", {7'd0, pin_drive_low}, {7'd0, e_low});
        else                 check("R6", {7'd0, pin_drive_low}, {7'd0, e_low});
        if (e_osc && tk) m_cnt = m_cnt + 15'd1;
        if (wr && a == 8'h8E) m_ctrl = {w[7:6], m_ctrl[5], w[4:0]};
        if (dn) m_ctrl[5] = 1'b0;
        if (wr && a == 8'h8E && w[5]) m_ctrl[5] = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        logic [7:0] a;
        seed = 32'd7;
        void'($urandom(seed));
        m_ctrl = 8'h1C;
        m_cnt  = '0;
        repeat (3) @(negedge clk);
        // R1: reset value
        bus_addr = 8'h0E; #1;
        check("R1", bus_rdata, 8'h1C);
        check("R1", {7'd0, conv_req}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: write at the read address is ignored
        step(1, 8'h0E, 8'hFF, 0, 1, 0, 0, 0);
        step(0, 8'h0E, 8'h00, 0, 1, 0, 0, 0);
        // R3: set, write 0 ignored, done clears, collision keeps set
        step(1, 8'h8E, 8'h24, 0, 1, 0, 0, 0);
        step(1, 8'h8E, 8'h04, 0, 1, 0, 0, 0);
        step(0, 8'h0E, 8'h00, 0, 1, 0, 0, 1);
        step(1, 8'h8E, 8'h24, 0, 1, 0, 0, 0);
        step(1, 8'h8E, 8'h24, 0, 1, 0, 0, 1);
        step(0, 8'h0E, 8'h00, 0, 1, 0, 0, 0);
        // R4/R8: battery with osc stop and pin off, then pin kept on battery
        step(1, 8'h8E, 8'h80, 1, 0, 1, 1, 0);
        step(0, 8'h0E, 8'h00, 1, 0, 1, 1, 0);
        step(1, 8'h8E, 8'h47, 1, 0, 1, 0, 0);
        step(0, 8'h0E, 8'h00, 1, 0, 0, 1, 0);

        // Random mix
        for (int i = 0; i < 20000; i++) begin
            case ($urandom_range(3))
                0:       a = 8'h0E;
                1, 2:    a = 8'h8E;
                default: a = 8'($urandom);
            endcase
            step(($urandom_range(3) == 0), a, 8'($urandom), 1'($urandom),
                 ($urandom_range(3) != 0), 1'($urandom), 1'($urandom),
                 ($urandom_range(7) == 0));
        end

        // R5: 1 Hz rate over a full slow period with continuous ticks
        step(1, 8'h8E, 8'h00, 1, 1, 0, 0, 0);
        for (int i = 0; i < 34000; i++) begin
            step(0, 8'h0E, 8'h00, 1, 1, 0, 0, 0);
            if (i % 1024 == 0)
                check("R5", {7'd0, pin_drive_low}, {7'd0, ~exp_sq(m_ctrl, m_cnt)});
        end
        // R5: each fast rate, divider held while oscillator stopped
        for (int r = 1; r < 4; r++) begin
            step(1, 8'h8E, 8'((r << 3) | 8'h80), 1, 1, 0, 0, 0);
            for (int i = 0; i < 40; i++)
                step(0, 8'h0E, 8'h00, 1'(i % 3 != 0), 1'(i < 20), 0, 0, 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule